// File: doc/BRIEF.md
# Board Control Register File

This block is the small register file that a processor evaluation board exposes on its local bus. A host addresses it with a 20-bit byte offset on a plain read/write bus. A write takes effect at the clock edge where it is presented. A read returns its data one cycle later, together with a valid strobe.

The register file drives an 8-bit LED bar and an eight-character ASCII display buffer, both as parallel output vectors. The display can be loaded one character at a time. It can also be loaded with a whole 32-bit word, which is rendered as eight uppercase hexadecimal digits. The block also holds these registers:
- a break/reset byte;
- a general-purpose output byte;
- the registers of a bit-banged I2C port, whose clock and data lines go to an attached serial EEPROM.

A write of one magic word to the software-reset offset raises a one-cycle reset request toward the rest of the board.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, reads return LED bar 0, break/reset 0x0A, GP output 0, I2C output-enable 0, I2C output word 3 and I2C select 1. Every display character is a space (0x20).
- R2: busRdValid is high exactly in the cycle after a cycle with busRdEn high, and busRdData holds the result in that cycle. A read and a write to the same offset in one cycle return the value from before the write.
- R3: Offsets with no register read as 0, and writes to them change nothing. This includes the switch register (0x200), the jumper register (0x210), unaligned or out-of-range display offsets, and the display offsets themselves when read.
- R4: Offset 0x208 reads 0x12 when BIG_ENDIAN is 1 and 0x10 when it is 0.
- R5: A write to 0x408 stores bits 7:0. The stored value reads back at 0x408 and drives ledBar from the cycle after the write.
- R6: A write to 0x410 loads all eight characters with the uppercase ASCII hex digits of the written word. Character i sits at dispText[8i+7:8i], and character 0 takes the most significant nibble.
- R7: A write to offset 0x418 + 8*i (i = 0..7) stores bits 7:0 of the data into character i only.
- R8: A write of exactly 0x00000042 to 0x500 drives resetReq high for the single following cycle. Any other value written there leaves resetReq low.
- R9: Break/reset (0x508) and GP output (0xA00) keep 8 bits, I2C output-enable (0xB08) keeps 2 bits, and I2C select (0xB18) keeps 1 bit. Each reads back zero-extended.
- R10: A write to 0xB10 stores the whole word, which reads back at 0xB10. From the next cycle, i2cScl follows bit 1 and i2cSda follows bit 0.
- R11: A read of 0xB00 returns the stored input value 3 with bit 0 replaced by eepromSda as sampled at the read edge. The result is 0x2 or 0x3.
- R12: A read of 0xA08 returns the I2C output word while I2C select is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 20 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| eepromSda | input | 1 | Data line driven back by the EEPROM |
| ledBar | output | 8 | LED bar state |
| dispText | output | 64 | Eight display characters, character i in bits 8i+7:8i |
| resetReq | output | 1 | One-cycle system reset request |
| i2cScl | output | 1 | I2C clock toward the EEPROM |
| i2cSda | output | 1 | I2C data toward the EEPROM |

## Verification
Two functions of this block can land in the same cycle: a read and a write to the same register, since both strobes may be high together. The bench provokes this by writing a new LED value and reading the LED offset in one cycle. It expects the returned data to be the old value, and it expects a following read to show the new one. The sampling of eepromSda during a read of the I2C input register is judged the same way: the bench changes the line between two reads and expects bit 0 of each result to match the level present at that read's edge.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 32;
  localparam int NUM_CHARS = DATA_W / 4;
  localparam int CHAR_W    = 8;
  localparam int IDX_W     = $clog2(NUM_CHARS);

  localparam logic [ADDR_W-1:0] OFS_SWITCH  = 20'h00200;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 20'h00208;
  localparam logic [ADDR_W-1:0] OFS_JUMPER  = 20'h00210;
  localparam logic [ADDR_W-1:0] OFS_LEDS    = 20'h00408;
  localparam logic [ADDR_W-1:0] OFS_HEXWORD = 20'h00410;
  localparam logic [ADDR_W-1:0] OFS_CHAR0   = 20'h00418;
  localparam logic [ADDR_W-1:0] OFS_SOFTRST = 20'h00500;
  localparam logic [ADDR_W-1:0] OFS_BRK     = 20'h00508;
  localparam logic [ADDR_W-1:0] OFS_GPOUT   = 20'h00A00;
  localparam logic [ADDR_W-1:0] OFS_GPIN    = 20'h00A08;
  localparam logic [ADDR_W-1:0] OFS_I2CIN   = 20'h00B00;
  localparam logic [ADDR_W-1:0] OFS_I2COE   = 20'h00B08;
  localparam logic [ADDR_W-1:0] OFS_I2COUT  = 20'h00B10;
  localparam logic [ADDR_W-1:0] OFS_I2CSEL  = 20'h00B18;

  localparam logic [DATA_W-1:0] SOFTRST_KEY = 32'h0000_0042;

  typedef enum logic [3:0] {
    RD_ZERO, RD_STATUS, RD_LEDS, RD_BRK, RD_GPOUT, RD_GPIN,
    RD_I2CIN, RD_I2COE, RD_I2COUT, RD_I2CSEL
  } rdSel_t;

  typedef struct packed {
    logic             ledWr;
    logic             hexWr;
    logic             charWr;
    logic [IDX_W-1:0] charIdx;
    logic             rstKeyWr;
    logic             brkWr;
    logic             gpoWr;
    logic             oeWr;
    logic             i2cOutWr;
    logic             selWr;
    logic             rdEn;
    rdSel_t           rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctrlStrobes_t      strobes,
  output logic              busRdValid
);

  logic [ADDR_W-1:0] charOfs;
  logic              charHit;

  always_comb begin
    charOfs = busAddr - OFS_CHAR0;
    charHit = (busAddr >= OFS_CHAR0) && (charOfs[2:0] == 3'b000)
              && (charOfs[ADDR_W-1:3] < NUM_CHARS);
  end

  always_comb begin
    strobes         = '0;
    strobes.rdSel   = RD_ZERO;
    strobes.rdEn    = busRdEn;
    strobes.charIdx = charOfs[3 +: IDX_W];
    strobes.charWr  = busWrEn && charHit;
    if (busWrEn) begin
      unique case (busAddr)
        OFS_LEDS:    strobes.ledWr    = 1'b1;
        OFS_HEXWORD: strobes.hexWr    = 1'b1;
        OFS_SOFTRST: strobes.rstKeyWr = (busWrData == SOFTRST_KEY);
        OFS_BRK:     strobes.brkWr    = 1'b1;
        OFS_GPOUT:   strobes.gpoWr    = 1'b1;
        OFS_I2COE:   strobes.oeWr     = 1'b1;
        OFS_I2COUT:  strobes.i2cOutWr = 1'b1;
        OFS_I2CSEL:  strobes.selWr    = 1'b1;
        default:     ;
      endcase
    end
    unique case (busAddr)
      OFS_STATUS: strobes.rdSel = RD_STATUS;
      OFS_LEDS:   strobes.rdSel = RD_LEDS;
      OFS_BRK:    strobes.rdSel = RD_BRK;
      OFS_GPOUT:  strobes.rdSel = RD_GPOUT;
      OFS_GPIN:   strobes.rdSel = RD_GPIN;
      OFS_I2CIN:  strobes.rdSel = RD_I2CIN;
      OFS_I2COE:  strobes.rdSel = RD_I2COE;
      OFS_I2COUT: strobes.rdSel = RD_I2COUT;
      OFS_I2CSEL: strobes.rdSel = RD_I2CSEL;
      default:    strobes.rdSel = RD_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdValid <= 1'b0;
    else       busRdValid <= busRdEn;
  end

endmodule

// File: rtl/board_ctrl_datapath.sv
module board_ctrl_datapath
  import board_ctrl_pkg::*;
#(
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter logic [7:0]  BRK_INIT   = 8'h0A,
  parameter logic [DATA_W-1:0] I2C_IN_INIT = 32'h3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [DATA_W-1:0]           busWrData,
  input  logic                        eepromSda,
  output logic [DATA_W-1:0]           busRdData,
  output logic [7:0]                  ledBar,
  output logic [NUM_CHARS*CHAR_W-1:0] dispText,
  output logic                        resetReq,
  output logic                        i2cScl,
  output logic                        i2cSda
);

  localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? 32'h12 : 32'h10;
  localparam logic [CHAR_W-1:0] BLANK      = 8'h20;

  logic [7:0]        ledReg, brkReg, gpoReg;
  logic [1:0]        oeReg;
  logic              selReg;
  logic [DATA_W-1:0] i2cOutReg;
  logic [DATA_W-1:0] rdMux;

  function automatic logic [CHAR_W-1:0] hexChar(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'h0, nib};
    else             return 8'h37 + {4'h0, nib};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledReg    <= '0;
      brkReg    <= BRK_INIT;
      gpoReg    <= '0;
      oeReg     <= '0;
      selReg    <= 1'b1;
      i2cOutReg <= 32'h3;
      resetReq  <= 1'b0;
    end else begin
      resetReq <= strobes.rstKeyWr;
      if (strobes.ledWr)    ledReg    <= busWrData[7:0];
      if (strobes.brkWr)    brkReg    <= busWrData[7:0];
      if (strobes.gpoWr)    gpoReg    <= busWrData[7:0];
      if (strobes.oeWr)     oeReg     <= busWrData[1:0];
      if (strobes.selWr)    selReg    <= busWrData[0];
      if (strobes.i2cOutWr) i2cOutReg <= busWrData;
    end
  end

  for (genvar g = 0; g < NUM_CHARS; g++) begin : gChar
    logic [CHAR_W-1:0] charReg;
    always_ff @(posedge clk) begin
      if (!rstN)
        charReg <= BLANK;
      else if (strobes.hexWr)
        charReg <= hexChar(busWrData[DATA_W-1-4*g -: 4]);
      else if (strobes.charWr && (strobes.charIdx == IDX_W'(g)))
        charReg <= busWrData[CHAR_W-1:0];
    end
    assign dispText[CHAR_W*g +: CHAR_W] = charReg;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_STATUS: rdMux = STATUS_VAL;
      RD_LEDS:   rdMux = {24'h0, ledReg};
      RD_BRK:    rdMux = {24'h0, brkReg};
      RD_GPOUT:  rdMux = {24'h0, gpoReg};
      RD_GPIN:   rdMux = selReg ? i2cOutReg : '0;
      RD_I2CIN:  rdMux = {I2C_IN_INIT[DATA_W-1:1], eepromSda};
      RD_I2COE:  rdMux = {30'h0, oeReg};
      RD_I2COUT: rdMux = i2cOutReg;
      RD_I2CSEL: rdMux = {31'h0, selReg};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdData <= '0;
    else if (strobes.rdEn) busRdData <= rdMux;
    else                   busRdData <= '0;
  end

  assign ledBar = ledReg;
  assign i2cScl = i2cOutReg[1];
  assign i2cSda = i2cOutReg[0];

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  input  logic [DATA_W-1:0]           busWrData,
  output logic [DATA_W-1:0]           busRdData,
  output logic                        busRdValid,
  input  logic                        eepromSda,
  output logic [7:0]                  ledBar,
  output logic [NUM_CHARS*CHAR_W-1:0] dispText,
  output logic                        resetReq,
  output logic                        i2cScl,
  output logic                        i2cSda
);

  ctrlStrobes_t strobes;

  board_ctrl_decode u_decode (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busWrData  (busWrData),
    .strobes    (strobes),
    .busRdValid (busRdValid)
  );

  board_ctrl_datapath #(.BIG_ENDIAN(BIG_ENDIAN)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .eepromSda (eepromSda),
    .busRdData (busRdData),
    .ledBar    (ledBar),
    .dispText  (dispText),
    .resetReq  (resetReq),
    .i2cScl    (i2cScl),
    .i2cSda    (i2cSda)
  );

endmodule

// File: rtl/board_ctrl_regs_checker.sv
module board_ctrl_regs_checker
  import board_ctrl_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic [ADDR_W-1:0]           busAddr,
  input logic                        busWrEn,
  input logic                        busRdEn,
  input logic [DATA_W-1:0]           busWrData,
  input logic [DATA_W-1:0]           busRdData,
  input logic                        busRdValid,
  input logic                        eepromSda,
  input logic [7:0]                  ledBar,
  input logic [NUM_CHARS*CHAR_W-1:0] dispText,
  input logic                        resetReq,
  input logic                        i2cScl,
  input logic                        i2cSda
);

  logic keyWrite, dispWrite;
  always_comb begin
    keyWrite  = busWrEn && busAddr == OFS_SOFTRST && busWrData == SOFTRST_KEY;
    dispWrite = busWrEn && (busAddr == OFS_HEXWORD ||
                (busAddr >= OFS_CHAR0 && busAddr <= 20'h00450 && busAddr[2:0] == 3'b000));
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);
  assert_led_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_LEDS) |=> ledBar == $past(busWrData[7:0]));
  assert_led_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == OFS_LEDS) |=> $stable(ledBar));
  assert_disp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dispWrite |=> $stable(dispText));
  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    keyWrite |=> resetReq);
  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !keyWrite |=> !resetReq);
  assert_i2c_pins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_I2COUT) |=>
      (i2cScl == $past(busWrData[1]) && i2cSda == $past(busWrData[0])));
  assert_i2c_in_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == OFS_I2CIN) |=> busRdData == {30'h0, 1'b1, $past(eepromSda)});

endmodule

bind board_ctrl_regs board_ctrl_regs_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .busRdValid (busRdValid),
  .eepromSda  (eepromSda),
  .ledBar     (ledBar),
  .dispText   (dispText),
  .resetReq   (resetReq),
  .i2cScl     (i2cScl),
  .i2cSda     (i2cSda)
);

// File: tb/board_ctrl_regs_bench.sv
module board_ctrl_regs_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic        eepromSda = 1'b1;
  logic [7:0]  ledBar;
  logic [63:0] dispText;
  logic        resetReq;
  logic        i2cScl, i2cSda;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  board_ctrl_regs u_board_ctrl_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .eepromSda(eepromSda), .ledBar(ledBar),
    .dispText(dispText), .resetReq(resetReq), .i2cScl(i2cScl), .i2cSda(i2cSda)
  );

  // Vector: {write, requirement number, offset, data, expected read value}
  localparam int NV = 30;
  localparam logic [88:0] VEC [NV] = '{
    {1'b0, 4'd1,  20'h00408, 32'h0,         32'h0},         // R1 LED reset
    {1'b0, 4'd1,  20'h00508, 32'h0,         32'h0000000A},  // R1 break reset
    {1'b0, 4'd1,  20'h00A00, 32'h0,         32'h0},         // R1 GP out reset
    {1'b0, 4'd1,  20'h00B08, 32'h0,         32'h0},         // R1 OE reset
    {1'b0, 4'd1,  20'h00B10, 32'h0,         32'h3},         // R1 I2C out reset
    {1'b0, 4'd1,  20'h00B18, 32'h0,         32'h1},         // R1 select reset
    {1'b0, 4'd12, 20'h00A08, 32'h0,         32'h3},         // R12 GP in, select=1
    {1'b0, 4'd3,  20'h00200, 32'h0,         32'h0},         // R3 switch
    {1'b0, 4'd3,  20'h00210, 32'h0,         32'h0},         // R3 jumper
    {1'b0, 4'd4,  20'h00208, 32'h0,         32'h10},        // R4 status, little-endian
    {1'b1, 4'd5,  20'h00408, 32'h123456A5,  32'h0},         // R5
    {1'b0, 4'd5,  20'h00408, 32'h0,         32'hA5},        // R5
    {1'b1, 4'd9,  20'h00508, 32'hFFFFFF3C,  32'h0},         // R9
    {1'b0, 4'd9,  20'h00508, 32'h0,         32'h3C},        // R9
    {1'b1, 4'd9,  20'h00A00, 32'h000001FF,  32'h0},         // R9
    {1'b0, 4'd9,  20'h00A00, 32'h0,         32'hFF},        // R9
    {1'b1, 4'd9,  20'h00B08, 32'h000000FF,  32'h0},         // R9
    {1'b0, 4'd9,  20'h00B08, 32'h0,         32'h3},         // R9
    {1'b1, 4'd9,  20'h00B18, 32'h000000FE,  32'h0},         // R9
    {1'b0, 4'd9,  20'h00B18, 32'h0,         32'h0},         // R9
    {1'b0, 4'd12, 20'h00A08, 32'h0,         32'h0},         // R12 select=0
    {1'b1, 4'd3,  20'h00200, 32'h000000FF,  32'h0},         // R3
    {1'b0, 4'd3,  20'h00200, 32'h0,         32'h0},         // R3
    {1'b1, 4'd3,  20'h00304, 32'h00000055,  32'h0},         // R3
    {1'b0, 4'd3,  20'h00304, 32'h0,         32'h0},         // R3
    {1'b1, 4'd10, 20'h00B10, 32'hDEADBEEE,  32'h0},         // R10
    {1'b0, 4'd10, 20'h00B10, 32'h0,         32'hDEADBEEE},  // R10
    {1'b1, 4'd12, 20'h00B18, 32'h00000001,  32'h0},         // R12
    {1'b0, 4'd12, 20'h00A08, 32'h0,         32'hDEADBEEE},  // R12 select=1
    {1'b0, 4'd3,  20'h00418, 32'h0,         32'h0}          // R3 display not readable
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doRead(input string req, input logic [19:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    check(req, {63'h0, busRdValid}, 64'h1);
    check(req, {32'h0, busRdData}, {32'h0, exp});
  endtask

  function automatic logic [63:0] textOf(input string s);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = s[i];
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 display reset", dispText, textOf("        "));
    check("R1 LED port reset", {56'h0, ledBar}, 64'h0);
    check("R2 valid idle", {63'h0, busRdValid}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[k][87:84], k);
      if (VEC[k][88]) doWrite(VEC[k][83:64], VEC[k][63:32]);
      else            doRead(tag, VEC[k][83:64], VEC[k][31:0]);
    end

    check("R5 ledBar port", {56'h0, ledBar}, 64'hA5);
    check("R10 scl", {63'h0, i2cScl}, 64'h1);
    check("R10 sda", {63'h0, i2cSda}, 64'h0);

    // R11: input register follows the EEPROM line
    eepromSda = 1'b0;
    doRead("R11 sda low", 20'h00B00, 32'h2);
    eepromSda = 1'b1;
    doRead("R11 sda high", 20'h00B00, 32'h3);

    // R6: whole-word hex rendering
    doWrite(20'h00410, 32'h9A0F3C7B);
    check("R6 hex word", dispText, textOf("9A0F3C7B"));

    // R7: single characters, plus ignored display offsets (R3)
    doWrite(20'h00418, 32'hFFFFFF61);
    doWrite(20'h00450, 32'h0000007A);
    check("R7 char writes", dispText, textOf("aA0F3C7z"));
    doWrite(20'h00458, 32'h21);
    doWrite(20'h0041C, 32'h21);
    check("R3 bad display offsets", dispText, textOf("aA0F3C7z"));

    // R8: software reset key
    doWrite(20'h00500, 32'h43);
    check("R8 wrong key", {63'h0, resetReq}, 64'h0);
    doWrite(20'h00500, 32'h142);
    check("R8 wide wrong key", {63'h0, resetReq}, 64'h0);
    doWrite(20'h00500, 32'h42);
    check("R8 pulse high", {63'h0, resetReq}, 64'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {63'h0, resetReq}, 64'h0);

    // R2: read and write of the same offset in one cycle
    @(negedge clk);
    busAddr = 20'h00408; busWrData = 32'h77; busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check("R2 collision valid", {63'h0, busRdValid}, 64'h1);
    check("R2 collision old data", {32'h0, busRdData}, 64'hA5);
    doRead("R2 after collision", 20'h00408, 32'h77);
    @(negedge clk);
    check("R2 valid drops", {63'h0, busRdValid}, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule